// File: doc/BRIEF.md
# Multiplexed-Bus Byte-Lane SRAM Interface

This block connects a host whose 16-bit bus alternates between address and data under a phase clock (E) to two byte-wide asynchronous SRAM banks: one bank holds the even-addressed bytes and the other holds the odd-addressed bytes. All of its inputs are sampled on a fast system clock. While E is low, the block takes the address from the shared bus. It also decodes the access kind from a low-byte strobe and address bit 0, and it raises the matching active-low chip selects. While E is high, it opens the output enable for reads or the per-bank write enables for writes, and it moves data between the bus byte lanes and the banks.

The even bank is tied to the upper byte lane of the bus, bus[15:8]. The odd bank is tied to the lower byte lane, bus[7:0]. Both banks receive the same word address, which is the latched bus address without bit 0. The strobe/A0 code that the host may not use on the external bus is reported on an error output, and no bank is touched for that cycle.

Top module: `sram_glue_top`

## Requirements
- R1: Reset (rstN low) state: csEvenN, csOddN, oeN, weEvenN and weOddN are 1; accessErr and busOutEn are 0; sramAddr is 0.
- R2: While eClk is sampled low, the bus value is captured as the address on every clock. sramAddr equals the captured bus bits [15:1] one clock later. sramAddr stays unchanged on every clock that follows a clock on which eClk was sampled high.
- R3: The access code is {lowStrobe, A0}, where A0 is bus bit 0 during E low. Code 00 selects both banks, code 01 selects only the odd bank, and code 10 selects only the even bank. Chip selects are active low. They take the decoded value one clock after the address is sampled, and they hold it through the E-high phase.
- R4: Code 11 sets accessErr to 1 and keeps both chip selects, oeN and both write enables at 1 for that cycle. accessErr is 0 for the other codes.
- R5: On a read (rwIn=1) with a legal code, oeN goes low one clock after eClk is sampled high. It returns high one clock after eClk is sampled low. oeN is never low on a write.
- R6: The write enable of a bank goes low only for a write (rwIn=0) that selects that bank, one clock after eClk is sampled high. It returns high one clock after eClk is sampled low. No write enable is low on a read.
- R7: Write data for the even bank is bus[15:8], and write data for the odd bank is bus[7:0]. After E falls, both hold the bus value last sampled while E was high.
- R8: busOutEn equals the inverse of oeN. While it is high, busOut[15:8] is the even bank's read data if that bank is selected and 0 otherwise, and busOut[7:0] is the odd bank's read data if that bank is selected and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| eClk | input | 1 | Bus phase clock: low = address phase, high = data phase |
| rwIn | input | 1 | 1 = read, 0 = write |
| lowStrobe | input | 1 | Low-byte strobe, part of the access code |
| busIn | input | 16 | Shared bus as seen by the block |
| busOut | output | 16 | Read data toward the host |
| busOutEn | output | 1 | Enable of the block's bus driver |
| sramAddr | output | 15 | Word address shared by both banks |
| csEvenN | output | 1 | Even bank chip select, active low |
| csOddN | output | 1 | Odd bank chip select, active low |
| oeN | output | 1 | Shared output enable, active low |
| weEvenN | output | 1 | Even bank write enable, active low |
| weOddN | output | 1 | Odd bank write enable, active low |
| evenWrData | output | 8 | Write data to the even bank |
| oddWrData | output | 8 | Write data to the odd bank |
| evenRdData | input | 8 | Read data from the even bank |
| oddRdData | input | 8 | Read data from the odd bank |
| accessErr | output | 1 | Disallowed access code flag |

## Verification
The bench runs all four strobe/A0 codes once as reads and once as writes. If the bench saw the two 8-bit codes swapped, the wrong bank would be enabled and the other lane would be zero or corrupted. If code 11 were decoded as a 16-bit access, chip selects and an enable would go low while the error flag stayed high. During the data phase the bench puts data on the bus, which would overwrite a latch that still followed the bus, so sramAddr would change. After E falls it puts a new address on the bus: a write-data register that kept sampling there would hold address bytes, and a write enable that did not release on E low would be caught in the address phase.

// File: rtl/sram_glue_pkg.sv
package sram_glue_pkg;
  typedef struct packed {
    logic latchAddr;
    logic captureData;
    logic driveBus;
    logic laneEven;
    logic laneOdd;
  } glueStrobes_t;
endpackage

// File: rtl/sram_glue_ctrl.sv
module sram_glue_ctrl
  import sram_glue_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         eClk,
  input  logic         rwIn,
  input  logic         lowStrobe,
  input  logic         a0In,
  output glueStrobes_t strobes,
  output logic         csEvenN,
  output logic         csOddN,
  output logic         oeN,
  output logic         weEvenN,
  output logic         weOddN,
  output logic         accessErr
);
  logic rwLat, selEven, selOdd, errLat;
  logic decEven, decOdd, decErr;

  always_comb begin
    unique case ({lowStrobe, a0In})
      2'b00:   begin decEven = 1'b1; decOdd = 1'b1; decErr = 1'b0; end
      2'b01:   begin decEven = 1'b0; decOdd = 1'b1; decErr = 1'b0; end
      2'b10:   begin decEven = 1'b1; decOdd = 1'b0; decErr = 1'b0; end
      default: begin decEven = 1'b0; decOdd = 1'b0; decErr = 1'b1; end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rwLat   <= 1'b1;
      selEven <= 1'b0;
      selOdd  <= 1'b0;
      errLat  <= 1'b0;
      oeN     <= 1'b1;
      weEvenN <= 1'b1;
      weOddN  <= 1'b1;
    end else if (!eClk) begin
      rwLat   <= rwIn;
      selEven <= decEven;
      selOdd  <= decOdd;
      errLat  <= decErr;
      oeN     <= 1'b1;
      weEvenN <= 1'b1;
      weOddN  <= 1'b1;
    end else begin
      oeN     <= !(rwLat && (selEven || selOdd));
      weEvenN <= !(!rwLat && selEven);
      weOddN  <= !(!rwLat && selOdd);
    end
  end

  assign csEvenN   = !selEven;
  assign csOddN    = !selOdd;
  assign accessErr = errLat;

  always_comb begin
    strobes.latchAddr   = !eClk;
    strobes.captureData = eClk && !rwLat;
    strobes.driveBus    = !oeN;
    strobes.laneEven    = selEven;
    strobes.laneOdd     = selOdd;
  end
endmodule

// File: rtl/sram_glue_datapath.sv
module sram_glue_datapath
  import sram_glue_pkg::*;
#(
  parameter int BUS_W = 16,
  localparam int LANE_W = BUS_W / 2,
  localparam int SRAM_AW = BUS_W - 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  glueStrobes_t       strobes,
  input  logic [BUS_W-1:0]   busIn,
  input  logic [LANE_W-1:0]  evenRdData,
  input  logic [LANE_W-1:0]  oddRdData,
  output logic [BUS_W-1:0]   busOut,
  output logic               busOutEn,
  output logic [SRAM_AW-1:0] sramAddr,
  output logic [LANE_W-1:0]  evenWrData,
  output logic [LANE_W-1:0]  oddWrData
);
  logic [BUS_W-1:0] addrLat, dataLat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrLat <= '0;
      dataLat <= '0;
    end else begin
      if (strobes.latchAddr)   addrLat <= busIn;
      if (strobes.captureData) dataLat <= busIn;
    end
  end

  assign sramAddr   = addrLat[BUS_W-1:1];
  assign evenWrData = dataLat[BUS_W-1:LANE_W];
  assign oddWrData  = dataLat[LANE_W-1:0];
  assign busOutEn   = strobes.driveBus;
  assign busOut     = {strobes.laneEven ? evenRdData : '0,
                       strobes.laneOdd  ? oddRdData  : '0};
endmodule

// File: rtl/sram_glue_top.sv
module sram_glue_top
  import sram_glue_pkg::*;
#(
  parameter int BUS_W = 16,
  localparam int LANE_W = BUS_W / 2,
  localparam int SRAM_AW = BUS_W - 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               eClk,
  input  logic               rwIn,
  input  logic               lowStrobe,
  input  logic [BUS_W-1:0]   busIn,
  output logic [BUS_W-1:0]   busOut,
  output logic               busOutEn,
  output logic [SRAM_AW-1:0] sramAddr,
  output logic               csEvenN,
  output logic               csOddN,
  output logic               oeN,
  output logic               weEvenN,
  output logic               weOddN,
  output logic [LANE_W-1:0]  evenWrData,
  output logic [LANE_W-1:0]  oddWrData,
  input  logic [LANE_W-1:0]  evenRdData,
  input  logic [LANE_W-1:0]  oddRdData,
  output logic               accessErr
);
  glueStrobes_t strobes;

  sram_glue_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .eClk(eClk), .rwIn(rwIn),
    .lowStrobe(lowStrobe), .a0In(busIn[0]), .strobes(strobes),
    .csEvenN(csEvenN), .csOddN(csOddN), .oeN(oeN),
    .weEvenN(weEvenN), .weOddN(weOddN), .accessErr(accessErr)
  );

  sram_glue_datapath #(.BUS_W(BUS_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busIn(busIn),
    .evenRdData(evenRdData), .oddRdData(oddRdData),
    .busOut(busOut), .busOutEn(busOutEn), .sramAddr(sramAddr),
    .evenWrData(evenWrData), .oddWrData(oddWrData)
  );
endmodule

// File: rtl/sram_glue_checker.sv
module sram_glue_checker #(
  parameter int SRAM_AW = 15
) (
  input logic               clk,
  input logic               rstN,
  input logic               eClk,
  input logic [SRAM_AW-1:0] sramAddr,
  input logic               csEvenN,
  input logic               csOddN,
  input logic               oeN,
  input logic               weEvenN,
  input logic               weOddN,
  input logic               busOutEn,
  input logic               accessErr
);
  a_r2_addr_held_in_data_phase: assert property (@(posedge clk) disable iff (!rstN)
    $past(eClk) |-> $stable(sramAddr));

  a_r4_error_blocks_selects: assert property (@(posedge clk) disable iff (!rstN)
    accessErr |-> (csEvenN && csOddN && oeN && weEvenN && weOddN));

  a_r5_oe_only_after_e_high: assert property (@(posedge clk) disable iff (!rstN)
    !oeN |-> $past(eClk));

  a_r6_we_even_needs_cs: assert property (@(posedge clk) disable iff (!rstN)
    !weEvenN |-> (!csEvenN && oeN));

  a_r6_we_odd_needs_cs: assert property (@(posedge clk) disable iff (!rstN)
    !weOddN |-> (!csOddN && oeN));

  a_r6_enables_off_after_e_low: assert property (@(posedge clk) disable iff (!rstN)
    !$past(eClk) |-> (weEvenN && weOddN && oeN));

  a_r8_driver_tracks_oe: assert property (@(posedge clk) disable iff (!rstN)
    busOutEn |-> !oeN);
endmodule

bind sram_glue_top sram_glue_checker #(.SRAM_AW(SRAM_AW)) uChecker (
  .clk(clk), .rstN(rstN), .eClk(eClk), .sramAddr(sramAddr),
  .csEvenN(csEvenN), .csOddN(csOddN), .oeN(oeN),
  .weEvenN(weEvenN), .weOddN(weOddN), .busOutEn(busOutEn),
  .accessErr(accessErr)
);

// File: tb/tb_sram_glue_top.sv
module tb_sram_glue_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic eClk = 1'b0, rwIn = 1'b1, lowStrobe = 1'b0;
  logic [15:0] busIn = '0;
  logic [15:0] busOut;
  logic busOutEn, csEvenN, csOddN, oeN, weEvenN, weOddN, accessErr;
  logic [14:0] sramAddr;
  logic [7:0] evenWrData, oddWrData;
  logic [7:0] evenRdData = 8'hC3, oddRdData = 8'h3C;
  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sram_glue_top dut (
    .clk(clk), .rstN(rstN), .eClk(eClk), .rwIn(rwIn), .lowStrobe(lowStrobe),
    .busIn(busIn), .busOut(busOut), .busOutEn(busOutEn), .sramAddr(sramAddr),
    .csEvenN(csEvenN), .csOddN(csOddN), .oeN(oeN), .weEvenN(weEvenN),
    .weOddN(weOddN), .evenWrData(evenWrData), .oddWrData(oddWrData),
    .evenRdData(evenRdData), .oddRdData(oddRdData), .accessErr(accessErr)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic checkReset();
    check("R1", "csEvenN", 32'(csEvenN), 1);
    check("R1", "csOddN", 32'(csOddN), 1);
    check("R1", "oeN", 32'(oeN), 1);
    check("R1", "we", 32'({weEvenN, weOddN}), 3);
    check("R1", "accessErr", 32'(accessErr), 0);
    check("R1", "busOutEn", 32'(busOutEn), 0);
    check("R1", "sramAddr", 32'(sramAddr), 0);
  endtask

  // one complete bus cycle: address phase, data phase, E fall
  task automatic busCycle(input bit isRead, input bit strobe, input logic [15:0] addr, input logic [15:0] data);
    bit selE, selO, err;
    logic [15:0] expRd;
    err  = strobe && addr[0];
    selE = !err && !addr[0];
    selO = !err && !(strobe && !addr[0]);
    @(negedge clk);
    eClk = 1'b0; rwIn = isRead; lowStrobe = strobe; busIn = addr;
    repeat (2) @(negedge clk);
    check("R2", "addr phase sramAddr", 32'(sramAddr), 32'(addr[15:1]));
    check("R3", "addr phase cs", 32'({csEvenN, csOddN}), 32'({!selE, !selO}));
    check("R4", "accessErr", 32'(accessErr), 32'(err));
    check("R5", "oeN low in addr phase", 32'(oeN), 1);
    check("R6", "we low in addr phase", 32'({weEvenN, weOddN}), 3);
    eClk = 1'b1; busIn = isRead ? 16'h5A5A : data;
    @(negedge clk);
    expRd = {selE ? evenRdData : 8'h00, selO ? oddRdData : 8'h00};
    check("R2", "data phase sramAddr", 32'(sramAddr), 32'(addr[15:1]));
    check("R3", "data phase cs", 32'({csEvenN, csOddN}), 32'({!selE, !selO}));
    check("R5", "oeN data phase", 32'(oeN), 32'(!(isRead && !err)));
    check("R6", "we data phase", 32'({weEvenN, weOddN}), 32'({!(!isRead && selE), !(!isRead && selO)}));
    check("R8", "busOutEn", 32'(busOutEn), 32'(isRead && !err));
    if (isRead && !err) check("R8", "busOut lanes", 32'(busOut), 32'(expRd));
    @(negedge clk);
    eClk = 1'b0; busIn = 16'hFFFE;
    @(negedge clk);
    check("R5", "oeN after E fall", 32'(oeN), 1);
    check("R6", "we after E fall", 32'({weEvenN, weOddN}), 3);
    check("R8", "busOutEn after E fall", 32'(busOutEn), 0);
    if (!isRead) check("R7", "write lanes", 32'({evenWrData, oddWrData}), 32'(data));
  endtask

  initial begin
    #100000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkReset();
    rstN = 1'b1;
    // R3 code 00, 01, 10 and R4 code 11, reads then writes
    busCycle(1'b1, 1'b0, 16'h1234, 16'h0000);
    busCycle(1'b1, 1'b0, 16'h4321, 16'h0000);
    busCycle(1'b1, 1'b1, 16'h8A60, 16'h0000);
    busCycle(1'b1, 1'b1, 16'h0F0F, 16'h0000);
    busCycle(1'b0, 1'b0, 16'h2468, 16'hA1B2);
    busCycle(1'b0, 1'b0, 16'h1357, 16'hC4D5);
    busCycle(1'b0, 1'b1, 16'h7FFE, 16'h96E7);
    busCycle(1'b0, 1'b1, 16'h0001, 16'h1122);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule